// File: doc/BRIEF.md
# Receive Buffer Ring Manager

This block keeps track of the ring of receive buffer descriptors that software prepares in system memory. Software programs four 16-bit ring pointers: ring start, ring end, fetch pointer and software fill pointer. It also programs one shared upper address half and an end-of-buffer threshold. On request the block reads a four-word descriptor from memory, one word at a time, through a valid/ready read port. The descriptor gives the block its current buffer address and the remaining word count of that buffer.

Each time the receive path reports a stored packet, the current buffer address moves past the packet and its appended 4-byte CRC, and the word count drops to match. When the remaining count falls below the threshold, the packet is marked as the last one in its buffer and the next descriptor is fetched without software help. When the fetch pointer catches up with the fill pointer, the block reports that it has run out of buffers and refuses further packets. Software clears that condition, and the clear itself starts the next fetch.

Top module: `rx_ring_mgr`

## Requirements
- R1: After reset, buf_addr, buf_words and rd_ptr read 0, exhausted, last_pkt, fetch_busy and mem_req_valid are low, rx_ready is high, and the end-of-buffer threshold holds 0x02F8.
- R2: A register write uses reg_sel 0 for ring start, 1 for ring end, 2 for fetch pointer, 3 for fill pointer, 4 for upper address and 5 for threshold. Writes to the four pointers store the value with bit 0 forced to 0. The upper address and the threshold keep all 16 bits.
- R3: A fetch reads four words, in this order: buffer address low, buffer address high, word count low, word count high. The words sit at byte address {upper, fetch pointer} plus 2·k in 16-bit mode (wide=0) or 4·k in 32-bit mode (wide=1). buf_addr and buf_words load when the fourth word arrives.
- R4: At the end of a fetch the fetch pointer advances by 8 (wide=0) or 16 (wide=1). If the result equals ring end, it reloads from ring start.
- R5: If the advanced fetch pointer equals the fill pointer, exhausted is set and rx_ready goes low.
- R6: An exh_clr pulse while exhausted is set clears it and starts a fetch. An exh_clr pulse while exhausted is clear has no effect and starts no fetch.
- R7: Only one memory read is outstanding at a time. A request stays valid with a stable address until mem_req_ready is seen.
- R8: An accepted pkt_done with length N adds N+4 to buf_addr and subtracts floor((N+4)/2) from buf_words.
- R9: When an accepted packet leaves buf_words below the threshold, last_pkt is set and a fetch starts. Otherwise last_pkt is cleared by that packet.
- R10: A pkt_done while rx_ready is low is ignored: buf_addr, buf_words and last_pkt keep their values.
- R11: A fetch request that arrives while a fetch is running is held and served afterwards, not dropped.
- R12: fetch_busy is high from the cycle after a fetch is requested until the last queued fetch completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide | input | 1 | 1 selects 32-bit descriptor spacing |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (R2 encoding) |
| reg_wdata | input | 16 | Register write data |
| cmd_fetch | input | 1 | Software descriptor fetch command |
| exh_clr | input | 1 | Clear exhausted status |
| pkt_done | input | 1 | Packet stored in current buffer |
| pkt_len | input | 16 | Stored packet length in bytes |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_addr | output | 32 | Memory read byte address |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | 16 | Memory read data |
| buf_addr | output | 32 | Current buffer address |
| buf_words | output | 32 | Remaining words in current buffer |
| rd_ptr | output | 16 | Fetch pointer |
| exhausted | output | 1 | Out-of-buffers status |
| rx_ready | output | 1 | Packets may be stored |
| last_pkt | output | 1 | Last packet in buffer flag |
| fetch_busy | output | 1 | Descriptor fetch running or queued |

## Verification
The bench places a fetch pointer one step before ring end to confirm the reload from ring start. A design that skips the wrap would read descriptors past the ring. It places the fill pointer one step ahead of the fetch pointer to provoke exhaustion, then sends a packet that a design with a missing refusal gate would count. It also clears the condition and expects a fresh fetch, which a design lacking the clear trigger would never start. Two fetch commands are issued back to back to expose a dropped request, and the memory withholds ready to catch an address that drifts or a request that is withdrawn. An odd packet length probes the halving of the byte count, and a packet that takes the count just under the threshold checks the automatic refill.

// File: rtl/rrm_pkg.sv
package rrm_pkg;
  localparam int DESC_WORDS = 4;

  localparam logic [2:0] SEL_START = 3'd0;
  localparam logic [2:0] SEL_END   = 3'd1;
  localparam logic [2:0] SEL_RDPTR = 3'd2;
  localparam logic [2:0] SEL_WRPTR = 3'd3;
  localparam logic [2:0] SEL_UPPER = 3'd4;
  localparam logic [2:0] SEL_EOB   = 3'd5;

  typedef enum logic [1:0] {
    F_IDLE = 2'd0,
    F_REQ  = 2'd1,
    F_RSP  = 2'd2,
    F_DONE = 2'd3
  } fetch_st_t;
endpackage

// File: rtl/rrm_ptr_regs.sv
module rrm_ptr_regs
  import rrm_pkg::*;
#(
  parameter int          PTR_W   = 16,
  parameter logic [15:0] EOB_RST = 16'h02F8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wide,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [PTR_W-1:0] wr_data,
  input  logic             adv,
  input  logic             exh_clr,
  output logic [PTR_W-1:0] rrp,
  output logic [PTR_W-1:0] upper,
  output logic [PTR_W-1:0] eob,
  output logic             exhausted,
  output logic             clr_fire
);
  localparam logic [PTR_W-1:0] EVEN_MASK = ~PTR_W'(1);

  logic [PTR_W-1:0] start_q, start_d, end_q, end_d, rrp_q, rrp_d;
  logic [PTR_W-1:0] wrp_q, wrp_d, upper_q, upper_d, eob_q, eob_d;
  logic             exh_q, exh_d;
  logic [PTR_W-1:0] step, rrp_inc, rrp_adv;
  logic             hit_wrp;

  assign step    = wide ? PTR_W'(16) : PTR_W'(8);
  assign rrp_inc = rrp_q + step;
  assign rrp_adv = (rrp_inc == end_q) ? start_q : rrp_inc;
  assign hit_wrp = adv && (rrp_adv == wrp_q);
  assign clr_fire = exh_clr && exh_q;

  always_comb begin
    start_d = start_q;
    end_d   = end_q;
    rrp_d   = rrp_q;
    wrp_d   = wrp_q;
    upper_d = upper_q;
    eob_d   = eob_q;
    exh_d   = exh_q;
    if (adv) rrp_d = rrp_adv;
    if (wr_en) begin
      case (wr_sel)
        SEL_START: start_d = wr_data & EVEN_MASK;
        SEL_END:   end_d   = wr_data & EVEN_MASK;
        SEL_RDPTR: rrp_d   = wr_data & EVEN_MASK;
        SEL_WRPTR: wrp_d   = wr_data & EVEN_MASK;
        SEL_UPPER: upper_d = wr_data;
        SEL_EOB:   eob_d   = wr_data;
        default:   ;
      endcase
    end
    if (clr_fire) exh_d = 1'b0;
    if (hit_wrp)  exh_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
      rrp_q   <= '0;
      wrp_q   <= '0;
      upper_q <= '0;
      eob_q   <= PTR_W'(EOB_RST);
      exh_q   <= 1'b0;
    end else begin
      start_q <= start_d;
      end_q   <= end_d;
      rrp_q   <= rrp_d;
      wrp_q   <= wrp_d;
      upper_q <= upper_d;
      eob_q   <= eob_d;
      exh_q   <= exh_d;
    end
  end

  assign rrp       = rrp_q;
  assign upper     = upper_q;
  assign eob       = eob_q;
  assign exhausted = exh_q;

  AST_RRP_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    rrp_q[0] == 1'b0); // R2
  AST_WRAP_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wr_en && (start_q != end_q)) |=> (rrp_q != end_q)); // R4
  AST_EXH_FROM_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exh_q) |-> $past(adv)); // R5
endmodule

// File: rtl/rrm_fetch.sv
module rrm_fetch
  import rrm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wide,
  input  logic                             trig,
  input  logic [ADDR_W-1:0]                base_addr,
  output logic                             mem_req_valid,
  output logic [ADDR_W-1:0]                mem_req_addr,
  input  logic                             mem_req_ready,
  input  logic                             mem_rsp_valid,
  input  logic [DATA_W-1:0]                mem_rsp_data,
  output logic                             desc_done,
  output logic [DESC_WORDS-1:0][DATA_W-1:0] desc_words,
  output logic                             busy
);
  localparam int IDX_W = $clog2(DESC_WORDS);
  localparam int OFF_W = IDX_W + 2;

  fetch_st_t         st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              pend_q, pend_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [DESC_WORDS-1:0] cap;
  logic [OFF_W-1:0]  word_off;
  logic [DATA_W-1:0] word_q [DESC_WORDS];

  assign word_off = wide ? {idx_q, 2'b00} : {1'b0, idx_q, 1'b0};

  always_comb begin
    st_d          = st_q;
    idx_d         = idx_q;
    pend_d        = pend_q;
    base_d        = base_q;
    mem_req_valid = 1'b0;
    desc_done     = 1'b0;
    cap           = '0;
    case (st_q)
      F_IDLE: begin
        if (pend_q || trig) begin
          st_d   = F_REQ;
          idx_d  = '0;
          base_d = base_addr;
          pend_d = pend_q && trig;
        end
      end
      F_REQ: begin
        mem_req_valid = 1'b1;
        if (trig) pend_d = 1'b1;
        if (mem_req_ready) st_d = F_RSP;
      end
      F_RSP: begin
        if (trig) pend_d = 1'b1;
        if (mem_rsp_valid) begin
          cap[idx_q] = 1'b1;
          if (idx_q == IDX_W'(DESC_WORDS - 1)) begin
            st_d = F_DONE;
          end else begin
            idx_d = idx_q + IDX_W'(1);
            st_d  = F_REQ;
          end
        end
      end
      F_DONE: begin
        desc_done = 1'b1;
        if (trig) pend_d = 1'b1;
        st_d = F_IDLE;
      end
      default: st_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= F_IDLE;
      idx_q  <= '0;
      pend_q <= 1'b0;
      base_q <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      pend_q <= pend_d;
      base_q <= base_d;
    end
  end

  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      word_q[g] <= '0;
      else if (cap[g]) word_q[g] <= mem_rsp_data;
    end
    assign desc_words[g] = word_q[g];
  end

  assign mem_req_addr = base_q + ADDR_W'(word_off);
  assign busy         = (st_q != F_IDLE) || pend_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R7
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> !mem_req_valid); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    desc_done |=> !desc_done); // R3
endmodule

// File: rtl/rrm_buf.sv
module rrm_buf
  import rrm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              load,
  input  logic [DESC_WORDS-1:0][DATA_W-1:0] desc_words,
  input  logic                              pkt_done,
  input  logic [LEN_W-1:0]                  pkt_len,
  input  logic                              rx_ready,
  input  logic [DATA_W-1:0]                 eob,
  output logic [2*DATA_W-1:0]               buf_addr,
  output logic [2*DATA_W-1:0]               buf_words,
  output logic                              last_pkt,
  output logic                              low_trig
);
  localparam int CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0] addr_q, addr_d, words_q, words_d;
  logic             last_q, last_d;
  logic             accept, low;
  logic [CNT_W-1:0] total, addr_nx, words_nx;

  assign accept   = pkt_done && rx_ready;
  assign total    = CNT_W'(pkt_len) + CNT_W'(4);
  assign addr_nx  = addr_q + total;
  assign words_nx = words_q - (total >> 1);
  assign low      = words_nx < CNT_W'(eob);
  assign low_trig = accept && !load && low;

  always_comb begin
    addr_d  = addr_q;
    words_d = words_q;
    last_d  = last_q;
    if (load) begin
      addr_d  = {desc_words[1], desc_words[0]};
      words_d = {desc_words[3], desc_words[2]};
    end else if (accept) begin
      addr_d  = addr_nx;
      words_d = words_nx;
      last_d  = low;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      words_q <= '0;
      last_q  <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      words_q <= words_d;
      last_q  <= last_d;
    end
  end

  assign buf_addr  = addr_q;
  assign buf_words = words_q;
  assign last_pkt  = last_q;

  AST_REFUSED_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && !rx_ready && !load) |=> ($stable(words_q) && $stable(addr_q))); // R10
  AST_LOW_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    low_trig |=> last_q); // R9
endmodule

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr
  import rrm_pkg::*;
#(
  parameter int          PTR_W   = 16,
  parameter int          LEN_W   = 16,
  parameter logic [15:0] EOB_RST = 16'h02F8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wide,
  input  logic               reg_we,
  input  logic [2:0]         reg_sel,
  input  logic [PTR_W-1:0]   reg_wdata,
  input  logic               cmd_fetch,
  input  logic               exh_clr,
  input  logic               pkt_done,
  input  logic [LEN_W-1:0]   pkt_len,
  output logic               mem_req_valid,
  output logic [2*PTR_W-1:0] mem_req_addr,
  input  logic               mem_req_ready,
  input  logic               mem_rsp_valid,
  input  logic [PTR_W-1:0]   mem_rsp_data,
  output logic [2*PTR_W-1:0] buf_addr,
  output logic [2*PTR_W-1:0] buf_words,
  output logic [PTR_W-1:0]   rd_ptr,
  output logic               exhausted,
  output logic               rx_ready,
  output logic               last_pkt,
  output logic               fetch_busy
);
  localparam int ADDR_W = 2 * PTR_W;

  logic rst_s1, rst_s2, rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end
  assign rst_i = rst_s2;

  logic [PTR_W-1:0] rrp, upper, eob;
  logic             clr_fire, low_trig, desc_done, trig;
  logic [DESC_WORDS-1:0][PTR_W-1:0] desc_words;

  assign trig     = cmd_fetch || clr_fire || low_trig;
  assign rx_ready = !exhausted;
  assign rd_ptr   = rrp;

  rrm_ptr_regs #(.PTR_W(PTR_W), .EOB_RST(EOB_RST)) u_regs (
    .clk       (clk),
    .rst_n     (rst_i),
    .wide      (wide),
    .wr_en     (reg_we),
    .wr_sel    (reg_sel),
    .wr_data   (reg_wdata),
    .adv       (desc_done),
    .exh_clr   (exh_clr),
    .rrp       (rrp),
    .upper     (upper),
    .eob       (eob),
    .exhausted (exhausted),
    .clr_fire  (clr_fire)
  );

  rrm_fetch #(.DATA_W(PTR_W), .ADDR_W(ADDR_W)) u_fetch (
    .clk           (clk),
    .rst_n         (rst_i),
    .wide          (wide),
    .trig          (trig),
    .base_addr     ({upper, rrp}),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .desc_done     (desc_done),
    .desc_words    (desc_words),
    .busy          (fetch_busy)
  );

  rrm_buf #(.DATA_W(PTR_W), .LEN_W(LEN_W)) u_buf (
    .clk        (clk),
    .rst_n      (rst_i),
    .load       (desc_done),
    .desc_words (desc_words),
    .pkt_done   (pkt_done),
    .pkt_len    (pkt_len),
    .rx_ready   (rx_ready),
    .eob        (eob),
    .buf_addr   (buf_addr),
    .buf_words  (buf_words),
    .last_pkt   (last_pkt),
    .low_trig   (low_trig)
  );

  AST_FETCH_BUSY: assert property (@(posedge clk) disable iff (!rst_i)
    (cmd_fetch || clr_fire) |=> fetch_busy); // R12
  AST_EXH_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_i)
    (exh_clr && !exhausted && !cmd_fetch && !low_trig && !fetch_busy) |=> !fetch_busy); // R6
endmodule

// File: tb/rx_ring_mgr_test.sv
module rx_ring_mgr_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wide, reg_we, cmd_fetch, exh_clr, pkt_done;
  logic [2:0]  reg_sel;
  logic [15:0] reg_wdata, pkt_len;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [31:0] mem_req_addr, buf_addr, buf_words;
  logic [15:0] mem_rsp_data, rd_ptr;
  logic        exhausted, rx_ready, last_pkt, fetch_busy;

  int checks = 0;
  int errors = 0;

  logic [15:0] mem [512];
  logic [31:0] addr_log [64];
  int          req_n = 0;

  always #2.5 clk = ~clk;

  rx_ring_mgr uut (
    .clk(clk), .rst_n(rst_n), .wide(wide), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cmd_fetch(cmd_fetch), .exh_clr(exh_clr),
    .pkt_done(pkt_done), .pkt_len(pkt_len), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .buf_addr(buf_addr), .buf_words(buf_words), .rd_ptr(rd_ptr),
    .exhausted(exhausted), .rx_ready(rx_ready), .last_pkt(last_pkt),
    .fetch_busy(fetch_busy)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        mem_rsp_valid      <= 1'b1;
        mem_rsp_data       <= mem[mem_req_addr[9:1]];
        addr_log[req_n % 64] <= mem_req_addr;
        req_n              <= req_n + 1;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] sel, logic [15:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic ring(logic [15:0] s, logic [15:0] e, logic [15:0] r, logic [15:0] w);
    wr_reg(3'd0, s); wr_reg(3'd1, e); wr_reg(3'd2, r); wr_reg(3'd3, w);
  endtask

  task automatic put_desc(int a, int step, logic [15:0] w0, logic [15:0] w1,
                          logic [15:0] w2, logic [15:0] w3);
    mem[(a >> 1) % 512]            = w0;
    mem[((a + step) >> 1) % 512]   = w1;
    mem[((a + 2*step) >> 1) % 512] = w2;
    mem[((a + 3*step) >> 1) % 512] = w3;
  endtask

  task automatic do_fetch();
    @(negedge clk); cmd_fetch = 1'b1;
    @(negedge clk); cmd_fetch = 1'b0;
  endtask

  task automatic do_pkt(logic [15:0] n);
    @(negedge clk); pkt_done = 1'b1; pkt_len = n;
    @(negedge clk); pkt_done = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 300; i++) begin
      if (!fetch_busy) break;
      @(negedge clk);
    end
    chk("R12 fetch completes", {31'd0, fetch_busy}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 buf_addr", buf_addr, 32'd0);
    chk("R1 buf_words", buf_words, 32'd0);
    chk("R1 rd_ptr", {16'd0, rd_ptr}, 32'd0);
    chk("R1 flags", {28'd0, exhausted, last_pkt, fetch_busy, mem_req_valid}, 32'd0);
    chk("R1 rx_ready", {31'd0, rx_ready}, 32'd1);
  endtask

  task automatic t_clr_idle();
    int n0 = req_n;
    @(negedge clk); exh_clr = 1'b1;
    @(negedge clk); exh_clr = 1'b0;
    chk("R6 clear while not exhausted starts nothing", {31'd0, fetch_busy}, 32'd0);
    repeat (4) @(negedge clk);
    chk("R6 no memory reads", req_n - n0, 32'd0);
  endtask

  task automatic t_mask();
    wr_reg(3'd2, 16'h0043);
    chk("R2 fetch pointer bit0 forced low", {16'd0, rd_ptr}, 32'h0042);
  endtask

  task automatic t_fetch16();
    int n0;
    wide = 1'b0;
    wr_reg(3'd4, 16'h0005);
    ring(16'h0040, 16'h0080, 16'h0040, 16'h0030);
    put_desc(16'h40, 2, 16'h1000, 16'h0002, 16'h0400, 16'h0000);
    n0 = req_n;
    do_fetch();
    chk("R12 busy after command", {31'd0, fetch_busy}, 32'd1);
    wait_idle();
    chk("R3 four reads", req_n - n0, 32'd4);
    chk("R3 addr word0", addr_log[n0 % 64], 32'h0005_0040);
    chk("R3 addr word3", addr_log[(n0 + 3) % 64], 32'h0005_0046);
    chk("R3 buf_addr 16-bit", buf_addr, 32'h0002_1000);
    chk("R3 buf_words 16-bit", buf_words, 32'h0000_0400);
    chk("R4 advance by 8", {16'd0, rd_ptr}, 32'h0048);
    wr_reg(3'd4, 16'h0000);
  endtask

  task automatic t_fetch32();
    int n0;
    wide = 1'b1;
    wr_reg(3'd2, 16'h0060);
    put_desc(16'h60, 4, 16'h2000, 16'h0003, 16'h0800, 16'h0001);
    n0 = req_n;
    do_fetch();
    wait_idle();
    chk("R3 addr word1 32-bit", addr_log[(n0 + 1) % 64], 32'h0000_0064);
    chk("R3 addr word3 32-bit", addr_log[(n0 + 3) % 64], 32'h0000_006C);
    chk("R3 buf_addr 32-bit", buf_addr, 32'h0003_2000);
    chk("R3 buf_words 32-bit", buf_words, 32'h0001_0800);
    chk("R4 advance by 16", {16'd0, rd_ptr}, 32'h0070);
    wide = 1'b0;
  endtask

  task automatic t_wrap();
    wr_reg(3'd0, 16'h0041);
    wr_reg(3'd2, 16'h0078);
    put_desc(16'h78, 2, 16'h0111, 16'h0000, 16'h0222, 16'h0000);
    do_fetch();
    wait_idle();
    chk("R4 wrap to ring start", {16'd0, rd_ptr}, 32'h0040);
    chk("R2 start bit0 forced low", {16'd0, rd_ptr}, 32'h0040);
    chk("R3 wrap descriptor", buf_addr, 32'h0000_0111);
  endtask

  task automatic t_backpressure();
    int n0 = req_n;
    mem_req_ready = 1'b0;
    do_fetch();
    repeat (4) @(negedge clk);
    chk("R7 request held", {31'd0, mem_req_valid}, 32'd1);
    chk("R7 address stable", mem_req_addr, 32'h0000_0040);
    chk("R7 nothing accepted", req_n - n0, 32'd0);
    mem_req_ready = 1'b1;
    wait_idle();
    chk("R7 fetch after stall", buf_addr, 32'h0002_1000);
  endtask

  task automatic t_exhaust();
    ring(16'h0100, 16'h0110, 16'h0100, 16'h0108);
    put_desc(16'h100, 2, 16'h3000, 16'h0000, 16'h0500, 16'h0000);
    put_desc(16'h108, 2, 16'h4000, 16'h0000, 16'h0600, 16'h0000);
    do_fetch();
    wait_idle();
    chk("R5 exhausted set", {31'd0, exhausted}, 32'd1);
    chk("R5 rx_ready low", {31'd0, rx_ready}, 32'd0);
    do_pkt(16'd20);
    chk("R10 words unchanged", buf_words, 32'h0000_0500);
    chk("R10 addr unchanged", buf_addr, 32'h0000_3000);
    @(negedge clk); exh_clr = 1'b1;
    @(negedge clk); exh_clr = 1'b0;
    chk("R6 exhausted cleared", {31'd0, exhausted}, 32'd0);
    chk("R6 clear starts fetch", {31'd0, fetch_busy}, 32'd1);
    wait_idle();
    chk("R6 next descriptor", buf_addr, 32'h0000_4000);
    chk("R4 wrap after clear", {16'd0, rd_ptr}, 32'h0100);
    chk("R5 no new exhaustion", {31'd0, exhausted}, 32'd0);
  endtask

  task automatic t_pkt();
    do_pkt(16'd60);
    chk("R8 addr +N+4", buf_addr, 32'h0000_4040);
    chk("R8 words -(N+4)/2", buf_words, 32'h0000_05E0);
    chk("R9 not last", {31'd0, last_pkt}, 32'd0);
    do_pkt(16'd61);
    chk("R8 odd length addr", buf_addr, 32'h0000_4081);
    chk("R8 odd length words", buf_words, 32'h0000_05C0);
  endtask

  task automatic t_last();
    ring(16'h0140, 16'h0160, 16'h0140, 16'h01F0);
    put_desc(16'h140, 2, 16'h5000, 16'h0000, 16'h0300, 16'h0000);
    put_desc(16'h148, 2, 16'h6000, 16'h0000, 16'h0900, 16'h0000);
    do_fetch();
    wait_idle();
    do_pkt(16'd8);
    chk("R9 above threshold", {31'd0, last_pkt}, 32'd0);
    chk("R9 words 0x2FA", buf_words, 32'h0000_02FA);
    do_pkt(16'd8);
    chk("R9 last flagged below 0x2F8", {31'd0, last_pkt}, 32'd1);
    chk("R9 auto fetch started", {31'd0, fetch_busy}, 32'd1);
    wait_idle();
    chk("R9 new buffer", buf_addr, 32'h0000_6000);
    chk("R9 new count", buf_words, 32'h0000_0900);
    chk("R4 pointer after auto fetch", {16'd0, rd_ptr}, 32'h0150);
  endtask

  task automatic t_threshold();
    wr_reg(3'd5, 16'h0000);
    do_pkt(16'h1000);
    chk("R2 threshold write", buf_words, 32'h0000_00FE);
    chk("R9 zero threshold no last", {31'd0, last_pkt}, 32'd0);
    chk("R9 zero threshold no fetch", {31'd0, fetch_busy}, 32'd0);
  endtask

  task automatic t_queue();
    int n0;
    ring(16'h0180, 16'h01C0, 16'h0180, 16'h01F0);
    put_desc(16'h180, 2, 16'h7000, 16'h0000, 16'h0100, 16'h0000);
    put_desc(16'h188, 2, 16'h8000, 16'h0000, 16'h0200, 16'h0000);
    n0 = req_n;
    do_fetch();
    @(negedge clk);
    do_fetch();
    wait_idle();
    chk("R11 both fetches served", req_n - n0, 32'd8);
    chk("R11 second descriptor", buf_addr, 32'h0000_8000);
    chk("R11 pointer advanced twice", {16'd0, rd_ptr}, 32'h0190);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R12 watchdog expired: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 16'h0;
    rst_n = 1'b0; wide = 1'b0; reg_we = 1'b0; reg_sel = 3'd0; reg_wdata = '0;
    cmd_fetch = 1'b0; exh_clr = 1'b0; pkt_done = 1'b0; pkt_len = '0;
    mem_req_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_clr_idle();
    t_mask();
    t_fetch16();
    t_fetch32();
    t_wrap();
    t_backpressure();
    t_exhaust();
    t_pkt();
    t_last();
    t_threshold();
    t_queue();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule